// File: doc/BRIEF.md
# Polled Asynchronous Serial Adapter

This block connects an 8-bit processor bus to one asynchronous serial line in each direction. Software sees four registers through a single register-select line: a control register and a transmit data register on the write side, a status register and a receive data register on the read side. The block is meant for polled I/O. Software reads the status register and checks the flag for the direction it wants. It then writes a character to send or reads a character that has arrived. It has no interrupt or modem lines.

The transmitter keeps the character steady in a hold register. A bit counter selects through a multiplexer which frame bit drives the line. The receiver shifts the line into a delay line at four samples per bit. It recognises a complete frame when the start edge reaches the far end of the window. It then reads every bit from a fixed tap at the centre of that bit. Both directions always carry 8 data bits. Parity and the number of stop bits come from the control register.

Top module: `serial_adapter`

## Requirements
- R1: A read with `cs_i` and `rd_i` high drives `data_oe_o` high. With `rs_i`=1 the read returns the receive data register, and with `rs_i`=0 it returns the status register. At all other times `data_oe_o` is low and `data_o` is 0. A write with `cs_i` low has no effect.
- R2: Status bit 0 is receive-full and bit 1 is transmit-empty. Bit 5 is overrun and bit 6 is parity error. Bits 7, 4, 3 and 2 always read 0.
- R3: A control write (`rs_i`=0) with data bits [1:0]=11 is a master reset. It clears receive-full, overrun and parity error, sets transmit-empty, stops any frame in progress with the line high, and discards any partly received frame.
- R4: Control bits [4:2] select the frame: 100=8N1, 101=8N2, 110=8E1, 111=8O1, 000=8E2, 001=8O2, 010=8E1, 011=8O1. Both directions use the same selection. After rst_ni the selection is 100.
- R5: A transmitted frame is a start bit (0), then data LSB first, then the parity bit if enabled, then the stop bits (1). Each bit lasts 4*SAMPLE_DIV clocks. Frames start on the shared bit-period boundary. The line is 1 when idle.
- R6: A data write (`rs_i`=1) loads the transmit data register and clears transmit-empty. Transmit-empty is set again on the clock in which the transmitter takes the character to start its frame. A waiting character follows the previous frame with no idle bit between them.
- R7: A received frame is sampled 4 times per bit. When it completes, its byte is put in the receive data register and receive-full is set. The parity error flag takes the parity result of that frame (0 when parity is off). The values of the stop bits are not checked.
- R8: A read of the receive data register clears receive-full and overrun.
- R9: A frame that completes while receive-full is set, and the receive data register is not read in that cycle, is discarded. Overrun is set, and the receive data register and parity error flag keep their values.
- R10: If a frame completes in the same cycle as a read of the receive data register, the read returns the old byte. The new byte is then kept, receive-full stays set and overrun is clear.
- R11: After rst_ni the status reads 0x02 and the transmit line is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rs_i | input | 1 | Register select: 0 control/status, 1 data |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data, 0 when not read |
| data_oe_o | output | 1 | High while the block drives read data |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |

## Verification
Two functions can meet in one clock edge: software reading the receive data register, and the receiver finishing a frame. The bench knows the cycle in which the receiver will finish, because that cycle follows from when it placed the start bit on the line. It schedules the data read on exactly that edge. The bench then expects the old byte on the bus, receive-full still set, no overrun, and the new byte on the next read. A second collision is a data write in the cycle where the transmitter takes the previous character. The reference model covers it by following the transmit line on every clock.

// File: rtl/serial_pkg.sv
package serial_pkg;
  localparam int MAX_FRAME = 12;

  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_fmt_t;

  // control[4:2] -> frame layout; 7-bit codes fold onto 8-bit frames
  function automatic frame_fmt_t decode_fmt(input logic [2:0] sel);
    frame_fmt_t f;
    f.par_en   = ~(sel[2] & ~sel[1]);
    f.par_odd  = sel[0];
    f.two_stop = (sel[2:1] == 2'b00) | (sel == 3'b101);
    return f;
  endfunction

  function automatic logic [3:0] frame_bits(input frame_fmt_t f);
    return 4'd10 + {3'd0, f.par_en} + {3'd0, f.two_stop};
  endfunction
endpackage

// File: rtl/serial_tick_gen.sv
module serial_tick_gen #(
  parameter int SAMPLE_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sample_tick_o,
  output logic bit_tick_o
);
  localparam int PW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

  logic [PW-1:0] pre_q;
  logic [1:0]    ph_q;

  assign sample_tick_o = (pre_q == PW'(SAMPLE_DIV - 1));
  assign bit_tick_o    = sample_tick_o && (ph_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      ph_q  <= '0;
    end else begin
      pre_q <= sample_tick_o ? '0 : pre_q + PW'(1);
      if (sample_tick_o) ph_q <= ph_q + 2'd1;
    end
  end
endmodule

// File: rtl/serial_tx_mux.sv
module serial_tx_mux
  import serial_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       bit_tick_i,
  input  frame_fmt_t fmt_i,
  input  logic       pend_i,
  input  logic [7:0] data_i,
  output logic       load_o,
  output logic       tx_o
);
  logic       act_q;
  logic [3:0] cnt_q;
  logic [7:0] hold_q;
  logic       last;
  logic       par;

  assign last   = (cnt_q == frame_bits(fmt_i) - 4'd1);
  assign load_o = bit_tick_i && pend_i && !clr_i && (!act_q || last);
  assign par    = ^hold_q ^ fmt_i.par_odd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (clr_i) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (bit_tick_i) begin
      if (load_o) begin
        hold_q <= data_i;
        cnt_q  <= '0;
        act_q  <= 1'b1;
      end else if (act_q) begin
        if (last) act_q <= 1'b0;
        else      cnt_q <= cnt_q + 4'd1;
      end
    end
  end

  // counter selects the frame bit
  always_comb begin
    tx_o = 1'b1;
    if (act_q) begin
      if (cnt_q == 4'd0)                        tx_o = 1'b0;
      else if (cnt_q <= 4'd8)                   tx_o = hold_q[3'(cnt_q - 4'd1)];
      else if (cnt_q == 4'd9 && fmt_i.par_en)   tx_o = par;
    end
  end

  a_r5_start_follows_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !tx_o);
  a_r5_line_holds_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_tick_i && !clr_i) |=> $stable(tx_o) || $past(clr_i));
endmodule

// File: rtl/serial_rx_tap.sv
module serial_rx_tap
  import serial_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       sample_tick_i,
  input  frame_fmt_t fmt_i,
  input  logic       rx_i,
  output logic       done_o,
  output logic [7:0] data_o,
  output logic       perr_o
);
  localparam int DL = 4 * MAX_FRAME + 1;
  localparam int IW = $clog2(DL);

  logic          s1_q, s2_q;
  logic [DL-1:0] dl_q;
  logic [IW-1:0] e_idx;
  logic          pbit;

  // age of the earliest start-bit sample once the frame is complete
  assign e_idx  = IW'(4 * int'(frame_bits(fmt_i)) - 1);
  assign done_o = sample_tick_i && !dl_q[e_idx] && dl_q[e_idx + IW'(1)]
                  && !dl_q[e_idx - IW'(2)];

  for (genvar k = 0; k < 8; k++) begin : g_tap
    assign data_o[k] = dl_q[e_idx - IW'(4 * k + 6)];
  end
  assign pbit   = dl_q[e_idx - IW'(38)];
  assign perr_o = fmt_i.par_en & (^data_o ^ pbit ^ fmt_i.par_odd);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      dl_q <= '1;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
      if (clr_i)              dl_q <= '1;
      else if (sample_tick_i) dl_q <= done_o ? '1 : {dl_q[DL-2:0], s2_q};
    end
  end

  a_r7_single_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/serial_adapter.sv
module serial_adapter
  import serial_pkg::*;
#(
  parameter int SAMPLE_DIV = 4  // clocks per sample, >= 3 for the input synchronizer
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_i,
  input  logic       rs_i,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic [7:0] data_i,
  output logic [7:0] data_o,
  output logic       data_oe_o,
  input  logic       rx_i,
  output logic       tx_o
);
  logic       sample_tick, bit_tick;
  logic [2:0] fmt_sel_q;
  frame_fmt_t fmt;
  logic [7:0] tdr_q, rdr_q, rx_byte;
  logic       tdre_q, rdrf_q, ovrn_q, pe_q;
  logic       wr_ctl, wr_tdr, rd_rdr, mreset;
  logic       tx_load, rx_done, rx_perr;
  logic [7:0] status;

  assign wr_ctl = cs_i && wr_i && !rs_i;
  assign wr_tdr = cs_i && wr_i && rs_i;
  assign rd_rdr = cs_i && rd_i && rs_i;
  assign mreset = wr_ctl && (data_i[1:0] == 2'b11);
  assign fmt    = decode_fmt(fmt_sel_q);

  serial_tick_gen #(.SAMPLE_DIV(SAMPLE_DIV)) u_tick (
    .clk_i, .rst_ni, .sample_tick_o(sample_tick), .bit_tick_o(bit_tick)
  );

  serial_tx_mux u_tx (
    .clk_i, .rst_ni, .clr_i(mreset), .bit_tick_i(bit_tick), .fmt_i(fmt),
    .pend_i(!tdre_q), .data_i(tdr_q), .load_o(tx_load), .tx_o
  );

  serial_rx_tap u_rx (
    .clk_i, .rst_ni, .clr_i(mreset), .sample_tick_i(sample_tick), .fmt_i(fmt),
    .rx_i, .done_o(rx_done), .data_o(rx_byte), .perr_o(rx_perr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmt_sel_q <= 3'b100;
      tdr_q     <= '0;
      tdre_q    <= 1'b1;
    end else begin
      if (wr_ctl) fmt_sel_q <= data_i[4:2];
      if (wr_tdr) tdr_q <= data_i;
      if (mreset)       tdre_q <= 1'b1;
      else if (wr_tdr)  tdre_q <= 1'b0;  // write wins over a same-cycle load
      else if (tx_load) tdre_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdr_q  <= '0;
      rdrf_q <= 1'b0;
      ovrn_q <= 1'b0;
      pe_q   <= 1'b0;
    end else if (mreset) begin
      rdrf_q <= 1'b0;
      ovrn_q <= 1'b0;
      pe_q   <= 1'b0;
    end else if (rx_done) begin
      if (rdrf_q && !rd_rdr) begin
        ovrn_q <= 1'b1;
      end else begin
        rdr_q  <= rx_byte;
        rdrf_q <= 1'b1;
        ovrn_q <= 1'b0;
        pe_q   <= rx_perr;
      end
    end else if (rd_rdr) begin
      rdrf_q <= 1'b0;
      ovrn_q <= 1'b0;
    end
  end

  assign status    = {1'b0, pe_q, ovrn_q, 3'b000, tdre_q, rdrf_q};
  assign data_oe_o = cs_i && rd_i;
  assign data_o    = data_oe_o ? (rs_i ? rdr_q : status) : 8'h00;

  a_r3_master_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreset |=> tdre_q && !rdrf_q && !ovrn_q && !pe_q && tx_o);
  a_r6_write_clears_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tdr |=> !tdre_q);
  a_r8_read_clears_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rdr && !rx_done && !mreset) |=> !rdrf_q && !ovrn_q);
  a_r9_overrun_keeps_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rdrf_q && !rd_rdr && !mreset) |=> ovrn_q && $stable(rdr_q) && $stable(pe_q));
  a_r10_read_meets_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rd_rdr && !mreset) |=> rdrf_q && !ovrn_q);
endmodule

// File: tb/tb_serial_adapter.sv
module tb_serial_adapter;
  localparam int DIV = 4;
  localparam int BITCLK = 4 * DIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] din = 8'h00;
  logic       rx = 1'b1;
  logic [7:0] dout;
  logic       oe, tx;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;

  // reference model state
  bit       bits_q[$];
  bit       pend = 1'b0;
  byte      m_tdr = 8'h00, m_rdr = 8'h00;
  bit       m_rdrf = 0, m_ovrn = 0, m_pe = 0;
  bit [2:0] m_fmt = 3'b100;
  int       arr_edge[$];
  byte      arr_byte[$];
  bit       arr_perr[$];
  bit       exp_tx = 1'b1;

  always #2 clk = ~clk;

  serial_adapter #(.SAMPLE_DIV(DIV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rs_i(rs), .rd_i(rd), .wr_i(wr),
    .data_i(din), .data_o(dout), .data_oe_o(oe), .rx_i(rx), .tx_o(tx)
  );

  function automatic void fmt_info(input bit [2:0] s, output bit pe, output bit po, output bit ts);
    case (s)
      3'b000: {pe, po, ts} = 3'b101;
      3'b001: {pe, po, ts} = 3'b111;
      3'b010: {pe, po, ts} = 3'b100;
      3'b011: {pe, po, ts} = 3'b110;
      3'b100: {pe, po, ts} = 3'b000;
      3'b101: {pe, po, ts} = 3'b001;
      3'b110: {pe, po, ts} = 3'b100;
      default: {pe, po, ts} = 3'b110;
    endcase
  endfunction

  function automatic void build_frame(input byte b, input bit flip_par, ref bit q[$]);
    bit pe, po, ts, p;
    fmt_info(m_fmt, pe, po, ts);
    p = 1'b0;
    q.push_back(1'b0);
    for (int i = 0; i < 8; i++) begin
      q.push_back(b[i]);
      p = p ^ b[i];
    end
    if (pe) q.push_back(p ^ po ^ flip_par);
    q.push_back(1'b1);
    if (ts) q.push_back(1'b1);
  endfunction

  function automatic byte exp_status();
    return {1'b0, m_pe, m_ovrn, 3'b000, ~pend, m_rdrf};
  endfunction

  // model advances on every edge from the inputs the bench holds
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0;
      bits_q.delete();
      pend = 0; m_rdrf = 0; m_ovrn = 0; m_pe = 0; m_fmt = 3'b100;
      exp_tx = 1'b1;
    end else begin
      bit mr, done, rdr_read;
      cyc++;
      mr = cs && wr && !rs && (din[1:0] == 2'b11);
      rdr_read = cs && rd && rs;
      done = (arr_edge.size() > 0) && (arr_edge[0] == cyc);
      if (mr) begin
        bits_q.delete();
        pend = 0;
      end else begin
        if (cyc % BITCLK == 0) begin
          if (bits_q.size() > 0) void'(bits_q.pop_front());
          if (bits_q.size() == 0 && pend) begin
            build_frame(m_tdr, 1'b0, bits_q);
            pend = 0;
          end
        end
        if (cs && wr && rs) begin
          m_tdr = din;
          pend = 1;
        end
      end
      if (mr) begin
        m_rdrf = 0; m_ovrn = 0; m_pe = 0;
        arr_edge.delete(); arr_byte.delete(); arr_perr.delete();
      end else if (done) begin
        byte b; bit p;
        void'(arr_edge.pop_front());
        b = arr_byte.pop_front();
        p = arr_perr.pop_front();
        if (m_rdrf && !rdr_read) m_ovrn = 1;
        else begin
          m_rdr = b; m_rdrf = 1; m_ovrn = 0; m_pe = p;
        end
      end else if (rdr_read) begin
        m_rdrf = 0; m_ovrn = 0;
      end
      if (cs && wr && !rs) m_fmt = din[4:2];
      exp_tx = (bits_q.size() > 0) ? bits_q[0] : 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // transmit line compared on every clock (R5)
  always @(posedge clk) begin
    #1;
    if (rst_n) check(tx === exp_tx, "R5 tx line", int'(tx), int'(exp_tx));
  end

  task automatic rd_now(input bit rsel, input string req, output byte got);
    byte exp;
    cs = 1; rd = 1; rs = rsel;
    #1;
    exp = rsel ? m_rdr : exp_status();
    got = dout;
    check(oe === 1'b1, "R1 oe during read", int'(oe), 1);
    check(dout === exp, req, int'(dout), int'(exp));
    @(negedge clk);
    cs = 0; rd = 0;
  endtask

  task automatic rd_reg(input bit rsel, input string req, output byte got);
    @(negedge clk);
    rd_now(rsel, req, got);
  endtask

  task automatic wr_reg(input bit rsel, input byte d);
    @(negedge clk);
    cs = 1; wr = 1; rs = rsel; din = d;
    @(negedge clk);
    cs = 0; wr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive one frame on rx; completion edge follows from the start-bit tick
  task automatic send_rx(input byte b, input bit flip_par);
    bit fb[$];
    bit pe, po, ts;
    int j0, nbits;
    build_frame(b, flip_par, fb);
    fmt_info(m_fmt, pe, po, ts);
    nbits = fb.size();
    @(negedge clk);
    while (cyc % DIV != 0) @(negedge clk);
    j0 = cyc;
    arr_edge.push_back(j0 + (4 * nbits + 1) * DIV);
    arr_byte.push_back(b);
    arr_perr.push_back(pe && flip_par);
    foreach (fb[i]) begin
      rx = fb[i];
      repeat (BITCLK) @(negedge clk);
    end
    rx = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    byte v;
    idle(3);
    rst_n = 1;

    // R11 reset state, R2 fixed zeros
    rd_reg(0, "R11 status after reset", v);
    check(v === 8'h02, "R11 status literal", int'(v), 8'h02);
    check(tx === 1'b1, "R11 tx idle", int'(tx), 1);

    // R1 deselected access
    @(negedge clk);
    cs = 0; wr = 1; rs = 1; din = 8'hFF; rd = 1;
    #1;
    check(oe === 1'b0, "R1 oe low without cs", int'(oe), 0);
    check(dout === 8'h00, "R1 data zero without cs", int'(dout), 0);
    @(negedge clk);
    wr = 0; rd = 0;
    rd_reg(0, "R1 write without cs ignored", v);
    check(v[1] === 1'b1, "R1 empty kept", int'(v[1]), 1);

    // R6 / R5 transmit, back-to-back
    wr_reg(1, 8'hA5);
    rd_reg(0, "R6 status after write", v);
    check(v[1] === 1'b0, "R6 empty cleared", int'(v[1]), 0);
    idle(30);
    rd_reg(0, "R6 empty after load", v);
    wr_reg(1, 8'h3C);
    rd_reg(0, "R6 second char waiting", v);
    idle(12 * BITCLK);

    // R7 receive 8N1
    send_rx(8'h5A, 0);
    idle(2 * DIV + 2);
    rd_reg(0, "R7 status after frame", v);
    check(v[0] === 1'b1, "R7 full set", int'(v[0]), 1);
    rd_reg(1, "R7 received byte", v);
    check(v === 8'h5A, "R7 byte literal", int'(v), 8'h5A);
    rd_reg(0, "R8 full cleared", v);

    // R9 overrun
    send_rx(8'h11, 0);
    send_rx(8'h22, 0);
    idle(2 * DIV + 2);
    rd_reg(0, "R9 overrun status", v);
    check(v === 8'h23, "R9 status literal", int'(v), 8'h23);
    rd_reg(1, "R9 first byte kept", v);
    check(v === 8'h11, "R9 byte literal", int'(v), 8'h11);
    rd_reg(0, "R8 overrun cleared", v);

    // R3 master reset during a frame
    wr_reg(1, 8'h81);
    idle(40);
    wr_reg(0, 8'h03);
    rd_reg(0, "R3 status after master reset", v);
    check(v === 8'h02, "R3 status literal", int'(v), 8'h02);
    idle(3 * BITCLK);

    // R4 formats with parity
    wr_reg(0, 8'h18);
    send_rx(8'h6B, 0);
    idle(2 * DIV + 2);
    rd_reg(0, "R4 8E1 good parity", v);
    rd_reg(1, "R4 8E1 byte", v);
    send_rx(8'h6B, 1);
    idle(2 * DIV + 2);
    rd_reg(0, "R7 8E1 parity error", v);
    check(v[6] === 1'b1, "R7 parity flag", int'(v[6]), 1);
    rd_reg(1, "R7 byte with parity error", v);
    wr_reg(0, 8'h04);
    send_rx(8'h0F, 1);
    idle(2 * DIV + 2);
    rd_reg(0, "R4 8O2 parity error", v);
    rd_reg(1, "R4 8O2 byte", v);
    wr_reg(1, 8'h96);
    idle(13 * BITCLK);
    wr_reg(0, 8'h00);
    wr_reg(1, 8'h55);
    idle(13 * BITCLK);
    wr_reg(0, 8'h14);
    wr_reg(1, 8'hF0);
    send_rx(8'hF0, 1);
    idle(2 * DIV + 2);
    rd_reg(0, "R4 8N2 no parity flag", v);
    check(v[6] === 1'b0, "R4 parity off", int'(v[6]), 0);
    rd_reg(1, "R4 8N2 byte", v);
    idle(4 * BITCLK);

    // R10 read in the completion cycle
    wr_reg(0, 8'h10);
    send_rx(8'h33, 0);
    idle(2 * DIV + 2);
    fork
      send_rx(8'h44, 0);
      begin
        int t;
        while (arr_edge.size() == 0) @(negedge clk);
        t = arr_edge[0];
        while (cyc != t - 1) @(negedge clk);
        rd_now(1, "R10 old byte on collision", v);
        check(v === 8'h33, "R10 old byte literal", int'(v), 8'h33);
      end
    join
    idle(2 * DIV + 2);
    rd_reg(0, "R10 status after collision", v);
    check(v === 8'h03, "R10 status literal", int'(v), 8'h03);
    rd_reg(1, "R10 new byte kept", v);
    check(v === 8'h44, "R10 new byte literal", int'(v), 8'h44);

    idle(20);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule